// File: doc/BRIEF.md
# Helicity Window Timing Generator

This block divides time into helicity windows, counted on a 20 MHz system clock. Each window starts with a settle interval and continues with a stable (integration) interval. Three outputs mark the windows. A settle gate is high during the settle interval. An integration gate is high during the stable interval. A one-cycle step strobe tells the downstream pattern sequencer to advance.

The step strobe fires a fixed 1 µs after the settle gate rises. The settle transition therefore leads every pattern-driven transition by 1 µs.

The block has two timing modes:

- **Free-running mode.** Software-style inputs in microseconds set both durations, and the window period is their sum.
- **Beam-sync mode.** The window period is a base sync period (30 Hz by default) divided by 1, 4 or 8. The stable time is that period minus the settle time. Windows are grouped so that one group spans one base period. The first window of each group stays in settle until a rising edge of the external sync input has been seen, which re-phases the sequence to that input. If no edge arrives within twice the base period, the block raises a loss flag and falls back to free-running timing until an edge returns.

All pins are plain control and status levels or strobes. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `helwin_timer`

## Requirements
- R1: While reset is low, all four outputs are low. The settle gate is high after the first rising clock edge that follows reset release.
- R2: In free-running mode the settle gate is high for settle_us×CLK_PER_US cycles. The integration gate is then high for stable_us×CLK_PER_US cycles, and the pattern repeats.
- R3: The settle time is clamped to the range 10 to 1000 µs in both modes. The settle gate never stays high for fewer than 10×CLK_PER_US cycles.
- R4: In free-running mode the stable time is clamped to the range 400 to 1,000,000 µs.
- R5: The step strobe is high for exactly one cycle per window, in the settle cycle with index CLK_PER_US, counting the first settle cycle as index 0.
- R6: The settle gate and the integration gate are never high together. After the first window starts, exactly one of them is high in every cycle.
- R7: Timing inputs are sampled once, at the start of each window. A change made during a window takes effect from the next window.
- R8: In beam-sync mode, freq_sel selects the window period P from the base period B = SYNC_PERIOD_US×CLK_PER_US cycles: 2'b00 gives B, 2'b01 gives B/4, 2'b10 gives B/8, and 2'b11 gives B. The stable interval lasts P minus the settle cycles, with a minimum of 1 cycle.
- R9: In beam-sync mode, the first window of each group holds in settle until a rising edge of sync_in has been seen during that settle. If the edge arrives after the settle time has elapsed, the integration gate rises on the third rising clock edge after sync_in goes high.
- R10: If the holding window sees no edge within 2×B cycles from its start, the settle lasts exactly 2×B cycles. sync_lost then goes high as the integration gate rises, and later windows use free-running timing.
- R11: While sync_lost is high, a rising edge of sync_in clears it on the third rising clock edge after sync_in goes high. Leaving beam-sync mode clears it on the next rising edge.
- R12: In beam-sync mode, a sync edge that arrives outside the settle of a group's first window does not alter any window's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sync | input | 1 | 1 selects beam-sync mode, 0 selects free-running mode |
| freq_sel | input | 2 | Beam-sync reversal frequency code |
| settle_us | input | 10 | Settle time in microseconds |
| stable_us | input | 20 | Free-running stable time in microseconds |
| sync_in | input | 1 | External sync, asynchronous to clk |
| settle_gate | output | 1 | High during the settle interval |
| integ_gate | output | 1 | High during the stable interval |
| step_strobe | output | 1 | One-cycle window-step pulse |
| sync_lost | output | 1 | Beam-sync lock lost, free-running fallback active |

## Verification
The outputs have fixed latencies from their stimuli:

- The settle gate rises one rising edge after reset release.
- The step strobe follows the settle rise by CLK_PER_US cycles.
- A sync edge that releases a hold, or that clears the loss flag, acts on the third rising edge after sync_in goes high.
- Leaving beam-sync mode clears the loss flag after one edge.
- A timing change shows in the window after the current one.

The bench changes inputs on falling edges and samples at the falling edge after the edge on which a result is due. For each window it counts the settle and stable lengths and the position of the strobe, then compares them with durations worked out from the microsecond inputs. After a configuration change it skips the one window that still carries the old settings. In beam-sync mode it lets the windows re-lock before it compares steady-state periods.

// File: rtl/helwin_pkg.sv
package helwin_pkg;

  // Programmable limits, in microseconds.
  localparam int SETTLE_MIN_US = 10;
  localparam int SETTLE_MAX_US = 1000;
  localparam int STABLE_MIN_US = 400;
  localparam int STABLE_MAX_US = 1_000_000;

  // Maximum windows per beam-sync group (divide-by-8).
  localparam int GRP_W = 3;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_STABLE = 2'd2
  } phase_e;

endpackage

// File: rtl/helwin_sync.sv
module helwin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  // Rising edge seen at the output of the synchroniser chain.
  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/helwin_cfg.sv
module helwin_cfg import helwin_pkg::*; #(
  parameter int CLK_PER_US = 20,
  parameter int BASE_CYC   = 666_660,
  parameter int CW         = 25,
  parameter int SET_W      = 10,
  parameter int STB_W      = 20
) (
  input  logic             mode_sync,
  input  logic             sync_lost,
  input  logic [1:0]       freq_sel,
  input  logic [SET_W-1:0] settle_us,
  input  logic [STB_W-1:0] stable_us,
  output logic [CW-1:0]    settle_cyc,
  output logic [CW-1:0]    stable_cyc,
  output logic             use_sync,
  output logic [GRP_W-1:0] div_m1
);

  localparam logic [SET_W-1:0] S_MIN  = SET_W'(SETTLE_MIN_US);
  localparam logic [SET_W-1:0] S_MAX  = SET_W'(SETTLE_MAX_US);
  localparam logic [STB_W-1:0] T_MIN  = STB_W'(STABLE_MIN_US);
  localparam logic [STB_W-1:0] T_MAX  = STB_W'(STABLE_MAX_US);
  localparam logic [CW-1:0]    BASE_C = CW'(BASE_CYC);
  localparam logic [CW-1:0]    CLK_C  = CW'(CLK_PER_US);

  logic [SET_W-1:0] s_us;
  logic [STB_W-1:0] t_us;
  logic [1:0]       shamt;
  logic [CW-1:0]    per_cyc;

  always_comb begin
    if (settle_us < S_MIN)      s_us = S_MIN;
    else if (settle_us > S_MAX) s_us = S_MAX;
    else                        s_us = settle_us;

    if (stable_us < T_MIN)      t_us = T_MIN;
    else if (stable_us > T_MAX) t_us = T_MAX;
    else                        t_us = stable_us;

    case (freq_sel)
      2'd1:    begin shamt = 2'd2; div_m1 = GRP_W'(3); end
      2'd2:    begin shamt = 2'd3; div_m1 = GRP_W'(7); end
      default: begin shamt = 2'd0; div_m1 = GRP_W'(0); end
    endcase

    per_cyc    = BASE_C >> shamt;
    settle_cyc = CW'(s_us) * CLK_C;
    use_sync   = mode_sync & ~sync_lost;

    if (use_sync)
      stable_cyc = (per_cyc > settle_cyc) ? (per_cyc - settle_cyc) : CW'(1);
    else
      stable_cyc = CW'(t_us) * CLK_C;
  end

endmodule

// File: rtl/helwin_seq.sv
module helwin_seq import helwin_pkg::*; #(
  parameter int CW        = 25,
  parameter int TW        = 21,
  parameter int TO_CYC    = 1_333_320,
  parameter int STROBE_AT = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sync,
  input  logic             rise,
  input  logic [CW-1:0]    nxt_settle,
  input  logic [CW-1:0]    nxt_stable,
  input  logic             nxt_use_sync,
  input  logic [GRP_W-1:0] nxt_div_m1,
  output logic             settle_gate,
  output logic             integ_gate,
  output logic             step_strobe,
  output logic             sync_lost
);

  phase_e           phase_q;
  logic [CW-1:0]    cnt_q, cur_s_q, cur_t_q;
  logic [GRP_W-1:0] grp_q, grp_n;
  logic [TW-1:0]    wcnt_q;
  logic             cur_sync_q, pend_q, lost_q, lost_n;
  logic             hold_grp, locked, tmo, settle_end, leave, load, lost_set;

  always_comb begin
    hold_grp   = (phase_q == PH_SETTLE) && cur_sync_q && mode_sync && !lost_q
                 && (grp_q == '0);
    locked     = pend_q | rise;
    tmo        = (wcnt_q == TW'(TO_CYC - 1));
    settle_end = (cnt_q == cur_s_q - CW'(1));
    leave      = (phase_q == PH_SETTLE)
                 && ((settle_end && (!hold_grp || locked)) || (hold_grp && tmo));
    load       = (phase_q == PH_IDLE)
                 || ((phase_q == PH_STABLE) && (cnt_q == cur_t_q - CW'(1)));
    grp_n      = (!nxt_use_sync || !cur_sync_q || grp_q >= nxt_div_m1)
                 ? '0 : grp_q + GRP_W'(1);
    lost_set   = hold_grp && tmo && !locked;
    lost_n     = mode_sync && (lost_set || (lost_q && !rise));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      cur_s_q    <= '0;
      cur_t_q    <= '0;
      grp_q      <= '0;
      cur_sync_q <= 1'b0;
      pend_q     <= 1'b0;
      wcnt_q     <= '0;
      lost_q     <= 1'b0;
    end else begin
      lost_q <= lost_n;
      if (load) begin
        phase_q    <= PH_SETTLE;
        cnt_q      <= '0;
        cur_s_q    <= nxt_settle;
        cur_t_q    <= nxt_stable;
        cur_sync_q <= nxt_use_sync;
        grp_q      <= grp_n;
        pend_q     <= 1'b0;
        wcnt_q     <= '0;
      end else if (leave) begin
        phase_q <= PH_STABLE;
        cnt_q   <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (!((phase_q == PH_SETTLE) && settle_end)) cnt_q <= cnt_q + CW'(1);
        if (hold_grp) begin
          wcnt_q <= wcnt_q + TW'(1);
          if (rise) pend_q <= 1'b1;
        end
      end
    end
  end

  assign settle_gate = (phase_q == PH_SETTLE);
  assign integ_gate  = (phase_q == PH_STABLE);
  assign step_strobe = (phase_q == PH_SETTLE) && (cnt_q == CW'(STROBE_AT));
  assign sync_lost   = lost_q;

endmodule

// File: rtl/helwin_timer.sv
module helwin_timer import helwin_pkg::*; #(
  parameter int CLK_PER_US     = 20,
  parameter int SYNC_PERIOD_US = 33333,
  parameter int SYNC_STAGES    = 2,
  localparam int SET_W = $clog2(SETTLE_MAX_US + 1),
  localparam int STB_W = $clog2(STABLE_MAX_US + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_sync,
  input  logic [1:0]       freq_sel,
  input  logic [SET_W-1:0] settle_us,
  input  logic [STB_W-1:0] stable_us,
  input  logic             sync_in,
  output logic             settle_gate,
  output logic             integ_gate,
  output logic             step_strobe,
  output logic             sync_lost
);

  localparam int BASE_CYC = SYNC_PERIOD_US * CLK_PER_US;
  localparam int TO_CYC   = 2 * BASE_CYC;
  localparam int CW       = $clog2(STABLE_MAX_US * CLK_PER_US + 1);
  localparam int TW       = $clog2(TO_CYC + 1);

  logic             rise;
  logic [CW-1:0]    nxt_settle, nxt_stable;
  logic             nxt_use_sync;
  logic [GRP_W-1:0] nxt_div_m1;

  helwin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (sync_in),
    .rise (rise)
  );

  helwin_cfg #(
    .CLK_PER_US(CLK_PER_US),
    .BASE_CYC  (BASE_CYC),
    .CW        (CW),
    .SET_W     (SET_W),
    .STB_W     (STB_W)
  ) u_cfg (
    .mode_sync (mode_sync),
    .sync_lost (sync_lost),
    .freq_sel  (freq_sel),
    .settle_us (settle_us),
    .stable_us (stable_us),
    .settle_cyc(nxt_settle),
    .stable_cyc(nxt_stable),
    .use_sync  (nxt_use_sync),
    .div_m1    (nxt_div_m1)
  );

  helwin_seq #(
    .CW       (CW),
    .TW       (TW),
    .TO_CYC   (TO_CYC),
    .STROBE_AT(CLK_PER_US)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sync   (mode_sync),
    .rise        (rise),
    .nxt_settle  (nxt_settle),
    .nxt_stable  (nxt_stable),
    .nxt_use_sync(nxt_use_sync),
    .nxt_div_m1  (nxt_div_m1),
    .settle_gate (settle_gate),
    .integ_gate  (integ_gate),
    .step_strobe (step_strobe),
    .sync_lost   (sync_lost)
  );

endmodule

// File: rtl/helwin_timer_chk.sv
module helwin_timer_chk #(
  parameter int CLK_PER_US    = 20,
  parameter int SETTLE_MIN_US = 10
) (
  input logic clk,
  input logic rst_n,
  input logic mode_sync,
  input logic settle_gate,
  input logic integ_gate,
  input logic step_strobe,
  input logic sync_lost
);

  localparam int MIN_CYC = SETTLE_MIN_US * CLK_PER_US;

  logic        prev_q;
  int unsigned run_q;
  logic        rise_now;
  int unsigned offs;

  assign rise_now = settle_gate && !prev_q;
  assign offs     = rise_now ? 0 : run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 0;
    end else begin
      prev_q <= settle_gate;
      if (rise_now)                run_q <= 1;
      else if (run_q != 32'hFFFF_FFFF) run_q <= run_q + 1;
    end
  end

  // R6: gates never overlap
  p_gate_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(settle_gate && integ_gate));

  // R5: strobe only at settle index CLK_PER_US
  p_strobe_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe |-> (settle_gate && offs == CLK_PER_US));

  // R5: strobe lasts one cycle
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe |=> !step_strobe);

  // R3: settle never shorter than the minimum
  p_settle_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!settle_gate && prev_q) |-> (run_q >= MIN_CYC));

  // R11: leaving beam-sync clears the flag
  p_lost_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sync |=> !sync_lost);

  // R10: flag rises together with the stable interval
  p_lost_at_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_lost) |-> integ_gate);

endmodule

bind helwin_timer helwin_timer_chk #(
  .CLK_PER_US   (CLK_PER_US),
  .SETTLE_MIN_US(helwin_pkg::SETTLE_MIN_US)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_sync  (mode_sync),
  .settle_gate(settle_gate),
  .integ_gate (integ_gate),
  .step_strobe(step_strobe),
  .sync_lost  (sync_lost)
);

// File: tb/helwin_timer_tb_top.sv
`timescale 1ns/1ps
module helwin_timer_tb_top;

  localparam int CPU     = 4;
  localparam int SYNC_US = 500;
  localparam int BASE    = CPU * SYNC_US;
  localparam int TO      = 2 * BASE;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sync = 1'b0;
  logic [1:0]  freq_sel = 2'd0;
  logic [9:0]  settle_us = 10'd12;
  logic [19:0] stable_us = 20'd400;
  logic        man_p = 1'b0;
  logic        gen_p = 1'b0;
  logic        gen_on = 1'b0;
  logic        sync_in;
  logic        settle_gate, integ_gate, step_strobe, sync_lost;

  assign sync_in = man_p | gen_p;

  always #2.5 clk = ~clk;

  helwin_timer #(.CLK_PER_US(CPU), .SYNC_PERIOD_US(SYNC_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sync(mode_sync), .freq_sel(freq_sel),
    .settle_us(settle_us), .stable_us(stable_us), .sync_in(sync_in),
    .settle_gate(settle_gate), .integ_gate(integ_gate),
    .step_strobe(step_strobe), .sync_lost(sync_lost)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Window monitor.
  int  cs, ct, coff, cn, last_s, last_t, last_off, last_n, nwin, excl_bad;
  bit  prev_s, have, started;
  initial begin
    cs = 0; ct = 0; coff = -1; cn = 0; nwin = 0; excl_bad = 0;
    last_s = 0; last_t = 0; last_off = 0; last_n = 0;
    prev_s = 0; have = 0; started = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (settle_gate && integ_gate) excl_bad++;
        if (started && !settle_gate && !integ_gate) excl_bad++;
        if (settle_gate && !prev_s) begin
          if (have) begin
            last_s = cs; last_t = ct; last_off = coff; last_n = cn; nwin++;
          end
          cs = 0; ct = 0; coff = -1; cn = 0; have = 1;
        end
        if (settle_gate) begin
          if (step_strobe) begin cn++; coff = cs; end
          cs++;
          started = 1;
        end else if (step_strobe) cn += 100;
        if (integ_gate) ct++;
        prev_s = settle_gate;
      end
    end
  end

  // Periodic sync source.
  initial begin
    int gph = 0;
    forever begin
      @(negedge clk);
      if (gen_on) begin
        if (gph == 0)  gen_p = 1'b1;
        if (gph == 10) gen_p = 1'b0;
        gph = (gph == BASE - 1) ? 0 : gph + 1;
      end else begin
        gen_p = 1'b0;
        gph = 0;
      end
    end
  end

  task automatic wait_win();
    int n0 = nwin;
    while (nwin == n0) @(negedge clk);
  endtask

  task automatic chk_win(input string req, input int s, input int t);
    chk(req, "settle length", last_s, s);
    chk(req, "stable length", last_t, t);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1", "settle in reset", settle_gate, 0);
    chk("R1", "integ in reset", integ_gate, 0);
    chk("R1", "strobe in reset", step_strobe, 0);
    chk("R1", "lost in reset", sync_lost, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "settle after release", settle_gate, 1);

    // R2/R5: free-running 12 us / 400 us
    wait_win();
    chk_win("R2", 48, 1600);
    chk("R5", "strobe offset", last_off, CPU);
    chk("R5", "strobe count", last_n, 1);

    // R7: change applies from next window
    settle_us = 10'd25; stable_us = 20'd450;
    wait_win();
    chk_win("R7", 48, 1600);
    wait_win();
    chk_win("R2", 100, 1800);

    // R3/R4: clamping
    settle_us = 10'd3; stable_us = 20'd5;
    wait_win(); wait_win();
    chk_win("R3", 40, 1600);
    chk("R4", "stable low clamp", last_t, 1600);
    settle_us = 10'd1023; stable_us = 20'd400;
    wait_win(); wait_win();
    chk_win("R3", 4000, 1600);
    chk("R5", "strobe count long settle", last_n, 1);

    // R9: beam-sync hold and release
    settle_us = 10'd10; mode_sync = 1'b1; freq_sel = 2'd0;
    wait_win();
    repeat (100) @(negedge clk);
    chk("R9", "holding in settle", settle_gate, 1);
    man_p = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9", "integ after 2 edges", integ_gate, 0);
    @(negedge clk);
    chk("R9", "integ after 3 edges", integ_gate, 1);
    repeat (8) @(negedge clk);
    man_p = 1'b0;
    gen_on = 1'b1;

    // R8: divide-by-1
    repeat (4) wait_win();
    chk_win("R8", 40, BASE - 40);
    chk("R5", "strobe offset sync", last_off, CPU);
    wait_win();
    chk_win("R8", 40, BASE - 40);

    // R12: stray edge mid-stable
    repeat (500) @(negedge clk);
    man_p = 1'b1;
    repeat (10) @(negedge clk);
    man_p = 1'b0;
    wait_win();
    chk_win("R12", 40, BASE - 40);
    wait_win();
    chk_win("R12", 40, BASE - 40);

    // R8: divide-by-4 and divide-by-8 and code 11
    freq_sel = 2'd1;
    repeat (10) wait_win();
    chk_win("R8", 40, BASE / 4 - 40);
    wait_win();
    chk_win("R8", 40, BASE / 4 - 40);
    freq_sel = 2'd2;
    repeat (20) wait_win();
    chk_win("R8", 40, BASE / 8 - 40);
    wait_win();
    chk_win("R8", 40, BASE / 8 - 40);
    freq_sel = 2'd3;
    repeat (4) wait_win();
    chk_win("R8", 40, BASE - 40);
    chk("R10", "no loss while locked", sync_lost, 0);

    // R10: timeout and fallback
    wait_win();
    gen_on = 1'b0;
    wait_win();
    chk("R10", "timeout settle", last_s, TO);
    chk("R10", "lost after timeout", sync_lost, 1);
    wait_win();
    chk_win("R10", 40, 1600);
    chk("R10", "lost held", sync_lost, 1);

    // R11: recovery by edge
    man_p = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R11", "lost after 2 edges", sync_lost, 1);
    @(negedge clk);
    chk("R11", "lost after 3 edges", sync_lost, 0);
    repeat (8) @(negedge clk);
    man_p = 1'b0;

    // R11: clear by leaving beam-sync
    wait_win(); wait_win();
    chk("R11", "lost after second timeout", sync_lost, 1);
    mode_sync = 1'b0;
    @(negedge clk);
    chk("R11", "lost after mode off", sync_lost, 0);

    chk("R6", "gate overlap or gap cycles", excl_bad, 0);
    summary();
    $finish;
  end

endmodule